// File: doc/BRIEF.md
# Six-Entry Dual-Clock FIFO with Trimmed Gray Pointers

This block carries data words from a write clock domain to an unrelated read clock domain. It stores up to six words. Six is even but not a power of two, so neither pointer can be a plain binary count passed through a synchronizer. Each pointer instead steps through a six-code, 3-bit Gray cycle. The cycle is the 8-code reflected Gray sequence with its two centre codes left out. The sequence is mirror-symmetric, so the trimmed cycle still moves one bit per step, and that includes the step that wraps back to the start.

Each pointer also carries a lap bit, which toggles when its code wraps. The lap bit is how full is told apart from empty. Each 4-bit pointer reaches the other domain through a two-flop synchronizer. Because of that, the write side raises full on its own edge but clears it only after the read progress has crossed over. The read side does the same with empty. A write when full and a read when empty are dropped. Read data is registered. Each side has its own active-low asynchronous reset.

Top module: `gray6_async_fifo`

## Requirements
- R1: While either reset is held and just after it is released, `wr_full` is 0, `rd_empty` is 1 and `rd_data` is 0.
- R2: Each pointer's 3-bit code steps 000, 001, 011, 111, 101, 100 and then back to 000. Every step changes exactly one code bit, and codes 010 and 110 never occur. The position of the code in this cycle (0 to 5) selects the storage entry.
- R3: The FIFO holds exactly six words. A pointer's lap bit toggles on the step from code 100 to code 000.
- R4: `wr_full` is 1 whenever the write pointer, compared with the synchronized read pointer, is six words ahead: same code, opposite lap bit. It rises after the write clock edge that accepts the sixth unread word.
- R5: `rd_empty` is 1 whenever the synchronized write pointer equals the read pointer, lap bit included. It rises after the read clock edge that takes the last word.
- R6: A write while `wr_full` is 1 is dropped. Its word never appears at the read side, and the write pointer does not move.
- R7: A read while `rd_empty` is 1 is dropped. The read pointer and `rd_data` keep their values.
- R8: An accepted read puts the oldest word on `rd_data` at that read clock edge. `rd_data` holds its value until the next accepted read.
- R9: After a read is accepted, `wr_full` can fall at the second write clock edge after that read edge, not earlier. After a write is accepted, `rd_empty` can fall at the second read clock edge after that write edge, not earlier.
- R10: Words leave in the order they were accepted, across any number of pointer laps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write domain clock |
| wr_rst_n | input | 1 | Write domain reset, active low, asynchronous |
| wr_en | input | 1 | Write request |
| wr_data | input | DATA_W | Word to store |
| wr_full | output | 1 | Six words are held, as seen from the write side |
| rd_clk | input | 1 | Read domain clock |
| rd_rst_n | input | 1 | Read domain reset, active low, asynchronous |
| rd_en | input | 1 | Read request |
| rd_data | output | DATA_W | Registered oldest word, updated on an accepted read |
| rd_empty | output | 1 | No word is held, as seen from the read side |

## Verification
Timing of each result:
- `wr_full` and `rd_empty` rise combinationally from the pointer registers, so each is due just after the accepting edge of its own clock.
- `rd_data` is due at the read edge that accepts the read.
- A flag clears only at the second edge of its own clock after the far side moves, because the far pointer passes through two synchronizer stages.

How the bench follows this timing:
- The bench model counts accepted words in each domain as integers.
- It passes each count through two model stages that are clocked by the opposite clock.
- It compares all three outputs at the falling edge of their own clock.
- The two clock periods are chosen so that rising edges of the two clocks never coincide. Each model sample therefore has only one correct value.

// File: rtl/g6f_pkg.sv
`timescale 1ns/1ps
package g6f_pkg;

  localparam int G6_DEPTH  = 6;
  localparam int G6_CODE_W = 3;
  localparam int G6_IDX_W  = $clog2(G6_DEPTH);

  typedef struct packed {
    logic                 lap;
    logic [G6_CODE_W-1:0] code;
  } g6_ptr_t;

  localparam int G6_PTR_W = $bits(g6_ptr_t);

  // Successor in the trimmed Gray cycle (reflected 8-code cycle minus 010 and 110)
  function automatic logic [G6_CODE_W-1:0] g6_next_code(input logic [G6_CODE_W-1:0] c);
    case (c)
      3'b000:  return 3'b001;
      3'b001:  return 3'b011;
      3'b011:  return 3'b111;
      3'b111:  return 3'b101;
      3'b101:  return 3'b100;
      default: return 3'b000;
    endcase
  endfunction

  // Position of a code within the cycle, used as storage index
  function automatic logic [G6_IDX_W-1:0] g6_index(input logic [G6_CODE_W-1:0] c);
    case (c)
      3'b000:  return G6_IDX_W'(0);
      3'b001:  return G6_IDX_W'(1);
      3'b011:  return G6_IDX_W'(2);
      3'b111:  return G6_IDX_W'(3);
      3'b101:  return G6_IDX_W'(4);
      3'b100:  return G6_IDX_W'(5);
      default: return G6_IDX_W'(0);
    endcase
  endfunction

  function automatic logic g6_is_last(input logic [G6_CODE_W-1:0] c);
    return c == 3'b100;
  endfunction

  function automatic g6_ptr_t g6_advance(input g6_ptr_t p);
    g6_ptr_t n;
    n.code = g6_next_code(p.code);
    n.lap  = p.lap ^ g6_is_last(p.code);
    return n;
  endfunction

  // Writer has lapped the reader: same slot, different lap
  function automatic logic g6_is_full(input g6_ptr_t w, input g6_ptr_t r);
    return (w.code == r.code) && (w.lap != r.lap);
  endfunction

  function automatic logic g6_is_empty(input g6_ptr_t w, input g6_ptr_t r);
    return w == r;
  endfunction

endpackage

// File: rtl/g6_ptr_seq.sv
`timescale 1ns/1ps
module g6_ptr_seq
  import g6f_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                step,
  output g6_ptr_t             ptr,
  output logic [G6_IDX_W-1:0] idx
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    ptr <= '0;
    else if (step) ptr <= g6_advance(ptr);
  end

  assign idx = g6_index(ptr.code);

endmodule

// File: rtl/g6_sync2.sv
`timescale 1ns/1ps
module g6_sync2 #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] stage [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) stage[s] <= '0;
    end else begin
      stage[0] <= d;
      for (int s = 1; s < STAGES; s++) stage[s] <= stage[s-1];
    end
  end

  assign q = stage[STAGES-1];

endmodule

// File: rtl/g6_store.sv
`timescale 1ns/1ps
module g6_store #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 6,
  parameter int IDX_W  = 3
) (
  input  logic              wr_clk,
  input  logic              we,
  input  logic [IDX_W-1:0]  waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              rd_clk,
  input  logic              rd_rst_n,
  input  logic              re,
  input  logic [IDX_W-1:0]  raddr,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] mem [DEPTH];

  for (genvar e = 0; e < DEPTH; e++) begin : g_ent
    always_ff @(posedge wr_clk) begin
      if (we && (waddr == IDX_W'(e))) mem[e] <= wdata;
    end
  end

  always_ff @(posedge rd_clk or negedge rd_rst_n) begin
    if (!rd_rst_n) rdata <= '0;
    else if (re)   rdata <= mem[raddr];
  end

endmodule

// File: rtl/gray6_async_fifo.sv
`timescale 1ns/1ps
module gray6_async_fifo
  import g6f_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              wr_clk,
  input  logic              wr_rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic              wr_full,
  input  logic              rd_clk,
  input  logic              rd_rst_n,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_empty
);

  // Named internal events, visible to the bound checker
  g6_ptr_t             wr_ptr, rd_ptr;
  g6_ptr_t             rd_ptr_in_wr, wr_ptr_in_rd;
  logic [G6_IDX_W-1:0] wr_idx, rd_idx;
  logic                wr_accept, rd_accept;
  logic [G6_PTR_W-1:0] rd_sync_q, wr_sync_q;

  assign wr_accept = wr_en & ~wr_full;
  assign rd_accept = rd_en & ~rd_empty;

  g6_ptr_seq u_wr_seq (
    .clk  (wr_clk),
    .rst_n(wr_rst_n),
    .step (wr_accept),
    .ptr  (wr_ptr),
    .idx  (wr_idx)
  );

  g6_ptr_seq u_rd_seq (
    .clk  (rd_clk),
    .rst_n(rd_rst_n),
    .step (rd_accept),
    .ptr  (rd_ptr),
    .idx  (rd_idx)
  );

  // Read pointer into write domain
  g6_sync2 #(.WIDTH(G6_PTR_W), .STAGES(2)) u_rd2wr (
    .clk  (wr_clk),
    .rst_n(wr_rst_n),
    .d    (rd_ptr),
    .q    (rd_sync_q)
  );

  // Write pointer into read domain
  g6_sync2 #(.WIDTH(G6_PTR_W), .STAGES(2)) u_wr2rd (
    .clk  (rd_clk),
    .rst_n(rd_rst_n),
    .d    (wr_ptr),
    .q    (wr_sync_q)
  );

  assign rd_ptr_in_wr = g6_ptr_t'(rd_sync_q);
  assign wr_ptr_in_rd = g6_ptr_t'(wr_sync_q);

  assign wr_full  = g6_is_full(wr_ptr, rd_ptr_in_wr);
  assign rd_empty = g6_is_empty(wr_ptr_in_rd, rd_ptr);

  g6_store #(.DATA_W(DATA_W), .DEPTH(G6_DEPTH), .IDX_W(G6_IDX_W)) u_store (
    .wr_clk  (wr_clk),
    .we      (wr_accept),
    .waddr   (wr_idx),
    .wdata   (wr_data),
    .rd_clk  (rd_clk),
    .rd_rst_n(rd_rst_n),
    .re      (rd_accept),
    .raddr   (rd_idx),
    .rdata   (rd_data)
  );

endmodule

// File: rtl/g6f_checker.sv
`timescale 1ns/1ps
module g6f_checker
  import g6f_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input logic              wr_clk,
  input logic              wr_rst_n,
  input logic              rd_clk,
  input logic              rd_rst_n,
  input logic              wr_en,
  input logic              rd_en,
  input logic              wr_full,
  input logic              rd_empty,
  input logic              wr_accept,
  input logic              rd_accept,
  input g6_ptr_t           wr_ptr,
  input g6_ptr_t           rd_ptr,
  input logic [DATA_W-1:0] rd_data
);

  // R2
  wr_one_bit_step_chk: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    (wr_ptr != $past(wr_ptr)) |-> ($countones(wr_ptr.code ^ $past(wr_ptr.code)) == 1));

  // R2
  rd_one_bit_step_chk: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    (rd_ptr != $past(rd_ptr)) |-> ($countones(rd_ptr.code ^ $past(rd_ptr.code)) == 1));

  // R2
  wr_legal_code_chk: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    (wr_ptr.code != 3'b010) && (wr_ptr.code != 3'b110));

  // R3
  wr_lap_toggle_chk: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    (wr_accept && wr_ptr.code == 3'b100) |=> (wr_ptr.code == 3'b000 && wr_ptr.lap != $past(wr_ptr.lap)));

  // R6
  no_overflow_chk: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    (wr_full && wr_en) |=> $stable(wr_ptr));

  // R7
  no_underflow_chk: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    (rd_empty && rd_en) |=> ($stable(rd_ptr) && $stable(rd_data)));

  // R8
  rd_data_hold_chk: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    !rd_accept |=> $stable(rd_data));

endmodule

bind gray6_async_fifo g6f_checker #(.DATA_W(DATA_W)) u_g6f_chk (
  .wr_clk   (wr_clk),
  .wr_rst_n (wr_rst_n),
  .rd_clk   (rd_clk),
  .rd_rst_n (rd_rst_n),
  .wr_en    (wr_en),
  .rd_en    (rd_en),
  .wr_full  (wr_full),
  .rd_empty (rd_empty),
  .wr_accept(wr_accept),
  .rd_accept(rd_accept),
  .wr_ptr   (wr_ptr),
  .rd_ptr   (rd_ptr),
  .rd_data  (rd_data)
);

// File: tb/test_gray6_async_fifo.sv
`timescale 1ns/100ps
module test_gray6_async_fifo;

  localparam int DW = 8;

  logic          wr_clk = 0, rd_clk = 0;
  logic          wr_rst_n = 0, rd_rst_n = 0;
  logic          wr_en = 0, rd_en = 0;
  logic [DW-1:0] wr_data = '0;
  logic          wr_full, rd_empty;
  logic [DW-1:0] rd_data;

  // 250 MHz write clock; 7 ns read clock, rising edges never coincide
  always #2   wr_clk = ~wr_clk;
  always #3.5 rd_clk = ~rd_clk;

  gray6_async_fifo #(.DATA_W(DW)) i_gray6_async_fifo (
    .wr_clk(wr_clk), .wr_rst_n(wr_rst_n), .wr_en(wr_en), .wr_data(wr_data), .wr_full(wr_full),
    .rd_clk(rd_clk), .rd_rst_n(rd_rst_n), .rd_en(rd_en), .rd_data(rd_data), .rd_empty(rd_empty)
  );

  int checks = 0, failures = 0;
  bit run_chk = 0, done = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Behavioural reference: counts of accepted words, two-stage delayed views
  int          wcnt = 0, rcnt = 0;
  int          rs1 = 0, rs2 = 0, ws1 = 0, ws2 = 0;
  logic [DW-1:0] q[$];
  logic [DW-1:0] exp_rd = '0;

  always @(posedge wr_clk or negedge wr_rst_n) begin
    if (!wr_rst_n) begin
      wcnt = 0; rs1 = 0; rs2 = 0;
    end else begin
      if (wr_en && (wcnt - rs2 != 6)) begin
        q.push_back(wr_data);
        wcnt++;
      end
      rs2 = rs1;
      rs1 = rcnt;
    end
  end

  always @(posedge rd_clk or negedge rd_rst_n) begin
    if (!rd_rst_n) begin
      rcnt = 0; ws1 = 0; ws2 = 0; exp_rd = '0;
    end else begin
      if (rd_en && (rcnt != ws2)) begin
        exp_rd = q.pop_front();
        rcnt++;
      end
      ws2 = ws1;
      ws1 = wcnt;
    end
  end

  // Compare on every clock, away from the rising edge
  always @(negedge wr_clk) if (run_chk) begin
    check(wr_full == ((wcnt - rs2) == 6), "R4 R9 wr_full", int'(wr_full), int'((wcnt - rs2) == 6));
  end

  always @(negedge rd_clk) if (run_chk) begin
    check(rd_empty == (rcnt == ws2), "R5 R9 rd_empty", int'(rd_empty), int'(rcnt == ws2));
    check(rd_data == exp_rd, "R8 R10 rd_data", int'(rd_data), int'(exp_rd));
  end

  task automatic write_burst(input int n, input logic [DW-1:0] base);
    for (int i = 0; i < n; i++) begin
      @(negedge wr_clk);
      wr_en = 1; wr_data = base + DW'(i);
    end
    @(negedge wr_clk);
    wr_en = 0;
  endtask

  task automatic read_burst(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge rd_clk);
      rd_en = 1;
    end
    @(negedge rd_clk);
    rd_en = 0;
  endtask

  initial begin
    #31;
    wr_rst_n = 1; rd_rst_n = 1;
    @(negedge wr_clk);
    // R1
    check(wr_full == 0,   "R1 wr_full after reset",  int'(wr_full),  0);
    check(rd_empty == 1,  "R1 rd_empty after reset", int'(rd_empty), 1);
    check(rd_data == '0,  "R1 rd_data after reset",  int'(rd_data),  0);
    run_chk = 1;

    // Nine writes with no reads: six taken, three dropped (R3, R6)
    write_burst(9, 8'hA0);
    repeat (4) @(negedge wr_clk);
    check(wr_full == 1, "R3 full after six words", int'(wr_full), 1);
    repeat (3) @(negedge rd_clk);
    check(rd_empty == 0, "R5 not empty with six words", int'(rd_empty), 0);

    // Eight reads: six words then two reads on empty (R7)
    read_burst(8);
    repeat (3) @(negedge rd_clk);
    check(rd_empty == 1, "R7 empty after drain", int'(rd_empty), 1);
    check(rd_data == 8'hA5, "R6 R7 last word kept, dropped writes absent", int'(rd_data), 8'hA5);
    repeat (4) @(negedge wr_clk);
    check(wr_full == 0, "R9 full cleared after drain", int'(wr_full), 0);

    // Concurrent traffic over many laps (R2 R3 R10)
    fork
      begin : wr_side
        logic [7:0] lf = 8'h5B;
        for (int i = 0; i < 2400; i++) begin
          @(negedge wr_clk);
          lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
          wr_en = (i < 1200) ? lf[0] | lf[2] : lf[1] & lf[3];
          wr_data = DW'(i * 7 + 3);
        end
        @(negedge wr_clk);
        wr_en = 0;
      end
      begin : rd_side
        logic [7:0] lr = 8'hC3;
        for (int i = 0; i < 1400; i++) begin
          @(negedge rd_clk);
          lr = {lr[6:0], lr[7] ^ lr[5] ^ lr[4] ^ lr[3]};
          rd_en = (i < 700) ? lr[0] & lr[1] : lr[0] | lr[2];
        end
        @(negedge rd_clk);
        rd_en = 0;
      end
    join
    read_burst(20);
    repeat (4) @(negedge rd_clk);
    // R2 R3: many laps of the six-code cycle completed with order intact
    check(wcnt > 60, "R2 R3 pointer laps exercised", wcnt, 60);
    check(rd_empty == 1 && q.size() == 0, "R10 all words delivered", q.size(), 0);
    run_chk = 0;
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge wr_clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule